// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block gathers up to 32 interrupt request lines and decides which of them, if any, may interrupt the code the core is running. Every line has an enable, a 4-bit urgency value (a smaller value is more urgent) and a two-bit status: idle, waiting, in service, or in service with a fresh request waiting. A configurable split divides the urgency value into a pre-emption group (upper bits) and a sub-priority (lower bits). The sub-priority orders waiting requests but never lets one handler interrupt another.

Each cycle the block picks the most urgent line that is waiting, enabled and not in service. Ties go to the lower line number. It then compares the winner's group value with the current execution level. When the winner's group value is strictly lower, the block raises `take_o` and presents the line number. The core answers with `ack_i` when it enters the handler, which pushes the handler's group level onto a 16-entry stack. It answers with `ret_i` when the handler returns, which pops the stack and restores the level of the interrupted context. With the stack empty the execution level is 16, one step below the least urgent programmable level.

A small controller state machine tracks nesting. Its states are `CTL_THREAD` (no handler running), `CTL_HANDLER` (1 to 15 handlers nested) and `CTL_SATURATED` (stack full, no further entry offered). Its transitions are:
- enter-first: `CTL_THREAD` to `CTL_HANDLER` on an accepted entry.
- nest-to-full: `CTL_HANDLER` to `CTL_SATURATED` on an entry that fills the stack.
- unwind-last: `CTL_HANDLER` to `CTL_THREAD` on a return from depth 1.
- unwind-from-full: `CTL_SATURATED` to `CTL_HANDLER` on a return.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every line is disabled, has urgency value 0 and shows status 00. The execution level is 16 and `take_o` is low, even when a request arrives before any enable is written.
- R2: Write port map:
  - address 0x00 loads the whole enable vector from `cfg_wdata_i[31:0]`.
  - address 0x03 loads the split, meaning the number of sub-priority bits, from `cfg_wdata_i[2:0]`; values above 4 act as 4.
  - address 0x20+n loads the urgency of line n from `cfg_wdata_i[7:4]`; bits 3:0 are discarded.
- R3: A line's waiting bit is set by `irq_i[n]` being high in a cycle, or by writing 1 to bit n at address 0x01. It is cleared by writing 1 to bit n at address 0x02. When a set and a clear meet in one cycle, the set wins.
- R4: Among lines that are waiting, enabled and not in service, the lowest 4-bit urgency value wins, which orders first by group and then by sub-priority. Equal values go to the lowest line number.
- R5: `take_o` is high exactly when a winner exists and its group value (urgency shifted right by the split) is strictly below the execution level. A disabled line is never offered.
- R6: `ack_i` while `take_o` is high and `ret_i` is low puts the offered line in service and clears its waiting bit. A request on that line in the same cycle leaves it at status 11. The execution level becomes that line's group value.
- R7: `ret_i` with at least one handler nested removes the newest handler from service; status 11 becomes 01. The execution level returns to that of the interrupted context, or 16 when none remains.
- R8: `line_state_o[2n+1:2n]` reports line n as 00 idle, 01 waiting, 10 in service, or 11 in service with a new request waiting.
- R9: The block ignores `ack_i` when `take_o` is low or when `ret_i` is high in the same cycle. It ignores `ret_i` with no handler nested. In `CTL_SATURATED` nothing is offered.
- R10: A waiting line whose group value equals the running handler's group value is not offered, even when its sub-priority is better.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_IRQ | Request lines, one per interrupt source |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register write address |
| cfg_wdata_i | input | DATA_W | Register write data |
| ack_i | input | 1 | Core has entered the offered handler |
| ret_i | input | 1 | Core has returned from the newest handler |
| take_o | output | 1 | A request may pre-empt now |
| take_id_o | output | ID_W | Line number of the offered request |
| exec_prio_o | output | PRIO_W+1 | Current execution level (16 when no handler runs) |
| line_state_o | output | 2*NUM_IRQ | Two status bits per line |

## Verification
A stack entry that is corrupted or dropped shows up on `exec_prio_o` in the cycle after the `ret_i` that exposes it. From then on `take_o` would also offer or hold back the wrong lines. A lost or stuck waiting bit or in-service bit shows on `line_state_o` one cycle after the write, request or handshake that should have moved it. The same fault changes `take_o` and `take_id_o` in that same cycle. A controller state that disagrees with the nesting depth shows up as `take_o` held low with a more urgent line waiting, or as a return that leaves the execution level unchanged.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;

    localparam logic [7:0] REG_ENABLE    = 8'h00;
    localparam logic [7:0] REG_PEND_SET  = 8'h01;
    localparam logic [7:0] REG_PEND_CLR  = 8'h02;
    localparam logic [7:0] REG_SPLIT     = 8'h03;
    localparam logic [7:0] REG_PRIO_BASE = 8'h20;

    typedef enum logic [1:0] {
        CTL_THREAD    = 2'd0,
        CTL_HANDLER   = 2'd1,
        CTL_SATURATED = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        LN_IDLE     = 2'b00,
        LN_WAITING  = 2'b01,
        LN_SERVING  = 2'b10,
        LN_SERV_WAIT = 2'b11
    } line_state_e;

endpackage

// File: rtl/nest_irq_line.sv
module nest_irq_line #(
    parameter int unsigned PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we_i,
    input  logic              en_d_i,
    input  logic              prio_we_i,
    input  logic [PRIO_W-1:0] prio_d_i,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic              enter_i,
    input  logic              leave_i,
    output logic              en_o,
    output logic [PRIO_W-1:0] prio_o,
    output logic [1:0]        state_o
);
    logic waiting_q;
    logic serving_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            prio_o <= '0;
        end else begin
            if (en_we_i) begin
                en_o <= en_d_i;
            end
            if (prio_we_i) begin
                prio_o <= prio_d_i;
            end
        end
    end

    // set dominates every clearing source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
        end else if (set_i) begin
            waiting_q <= 1'b1;
        end else if (clr_i || enter_i) begin
            waiting_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            serving_q <= 1'b0;
        end else if (enter_i) begin
            serving_q <= 1'b1;
        end else if (leave_i) begin
            serving_q <= 1'b0;
        end
    end

    assign state_o = {serving_q, waiting_q};

endmodule

// File: rtl/nest_irq_arb.sv
module nest_irq_arb #(
    parameter int unsigned NUM_IRQ = 32,
    parameter int unsigned PRIO_W  = 4,
    localparam int unsigned ID_W   = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]        cand_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    output logic                      valid_o,
    output logic [ID_W-1:0]           id_o,
    output logic [PRIO_W-1:0]         prio_o
);
    // strict compare keeps the lowest index on equal values
    always_comb begin
        valid_o = 1'b0;
        id_o    = '0;
        prio_o  = '1;
        for (int i = 0; i < int'(NUM_IRQ); i++) begin
            if (cand_i[i] && (!valid_o || (prio_i[i*PRIO_W +: PRIO_W] < prio_o))) begin
                valid_o = 1'b1;
                id_o    = ID_W'(i);
                prio_o  = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/nest_irq_stack.sv
module nest_irq_stack #(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned ID_W     = 5,
    parameter int unsigned LVL_W    = 5,
    parameter int unsigned BASE_LVL = 16,
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [ID_W-1:0]  push_id_i,
    input  logic [LVL_W-1:0] push_lvl_i,
    input  logic             pop_i,
    output logic [CNT_W-1:0] depth_o,
    output logic [ID_W-1:0]  top_id_o,
    output logic [LVL_W-1:0] exec_lvl_o
);
    logic [ID_W-1:0]  id_q  [DEPTH];
    logic [LVL_W-1:0] lvl_q [DEPTH];
    logic [CNT_W-1:0] depth_q;
    logic [IDX_W-1:0] push_idx;
    logic [IDX_W-1:0] top_idx;

    assign push_idx = IDX_W'(depth_q);
    assign top_idx  = IDX_W'(depth_q - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
            for (int k = 0; k < int'(DEPTH); k++) begin
                id_q[k]  <= '0;
                lvl_q[k] <= '0;
            end
        end else if (push_i && (depth_q != CNT_W'(DEPTH))) begin
            id_q[push_idx]  <= push_id_i;
            lvl_q[push_idx] <= push_lvl_i;
            depth_q         <= depth_q + CNT_W'(1);
        end else if (pop_i && (depth_q != '0)) begin
            depth_q <= depth_q - CNT_W'(1);
        end
    end

    assign depth_o    = depth_q;
    assign top_id_o   = id_q[top_idx];
    assign exec_lvl_o = (depth_q == '0) ? LVL_W'(BASE_LVL) : lvl_q[top_idx];

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nest_irq_pkg::*;
#(
    parameter int unsigned NUM_IRQ     = 32,
    parameter int unsigned PRIO_W      = 4,
    parameter int unsigned STACK_DEPTH = 16,
    parameter int unsigned DATA_W      = 32,
    localparam int unsigned ID_W       = $clog2(NUM_IRQ),
    localparam int unsigned LVL_W      = PRIO_W + 1,
    localparam int unsigned SPLIT_W    = $clog2(PRIO_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_IRQ-1:0]   irq_i,
    input  logic                 cfg_we_i,
    input  logic [7:0]           cfg_addr_i,
    input  logic [DATA_W-1:0]    cfg_wdata_i,
    input  logic                 ack_i,
    input  logic                 ret_i,
    output logic                 take_o,
    output logic [ID_W-1:0]      take_id_o,
    output logic [LVL_W-1:0]     exec_prio_o,
    output logic [2*NUM_IRQ-1:0] line_state_o
);
    localparam int unsigned CNT_W    = $clog2(STACK_DEPTH + 1);
    localparam int unsigned BASE_LVL = 1 << PRIO_W;
    localparam int unsigned PRIO_LSB = 8 - PRIO_W;

    ctl_state_e ctl_q, ctl_d;

    logic [SPLIT_W-1:0]        split_q;
    logic [NUM_IRQ-1:0]        en_vec;
    logic [NUM_IRQ-1:0]        cand_vec;
    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    logic                      win_valid;
    logic [ID_W-1:0]           win_id;
    logic [PRIO_W-1:0]         win_prio;
    logic [LVL_W-1:0]          win_lvl;
    logic [CNT_W-1:0]          stk_depth;
    logic [ID_W-1:0]           stk_top_id;
    logic [LVL_W-1:0]          stk_exec;
    logic                      take_allow;
    logic                      ret_allow;
    logic                      do_ack;
    logic                      do_ret;
    logic                      wr_en;
    logic                      wr_pset;
    logic                      wr_pclr;
    logic                      wr_split;

    assign wr_en    = cfg_we_i && (cfg_addr_i == REG_ENABLE);
    assign wr_pset  = cfg_we_i && (cfg_addr_i == REG_PEND_SET);
    assign wr_pclr  = cfg_we_i && (cfg_addr_i == REG_PEND_CLR);
    assign wr_split = cfg_we_i && (cfg_addr_i == REG_SPLIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            split_q <= '0;
        end else if (wr_split) begin
            if (cfg_wdata_i[SPLIT_W-1:0] > SPLIT_W'(PRIO_W)) begin
                split_q <= SPLIT_W'(PRIO_W);
            end else begin
                split_q <= cfg_wdata_i[SPLIT_W-1:0];
            end
        end
    end

    // one status cell per request line
    for (genvar g = 0; g < int'(NUM_IRQ); g++) begin : g_line
        localparam logic [7:0] PRIO_ADDR = REG_PRIO_BASE + 8'(g);
        logic [1:0] st;

        nest_irq_line #(.PRIO_W(PRIO_W)) line_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_we_i   (wr_en),
            .en_d_i    (cfg_wdata_i[g]),
            .prio_we_i (cfg_we_i && (cfg_addr_i == PRIO_ADDR)),
            .prio_d_i  (cfg_wdata_i[7:PRIO_LSB]),
            .set_i     (irq_i[g] || (wr_pset && cfg_wdata_i[g])),
            .clr_i     (wr_pclr && cfg_wdata_i[g]),
            .enter_i   (do_ack && (take_id_o == ID_W'(g))),
            .leave_i   (do_ret && (stk_top_id == ID_W'(g))),
            .en_o      (en_vec[g]),
            .prio_o    (prio_flat[g*PRIO_W +: PRIO_W]),
            .state_o   (st)
        );

        assign line_state_o[2*g +: 2] = st;
        assign cand_vec[g] = en_vec[g] && (st == LN_WAITING);
    end

    nest_irq_arb #(
        .NUM_IRQ (NUM_IRQ),
        .PRIO_W  (PRIO_W)
    ) arb_i (
        .cand_i  (cand_vec),
        .prio_i  (prio_flat),
        .valid_o (win_valid),
        .id_o    (win_id),
        .prio_o  (win_prio)
    );

    // pre-emption uses the group field only
    assign win_lvl = LVL_W'(win_prio >> split_q);

    nest_irq_stack #(
        .DEPTH    (STACK_DEPTH),
        .ID_W     (ID_W),
        .LVL_W    (LVL_W),
        .BASE_LVL (BASE_LVL)
    ) stack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (do_ack),
        .push_id_i  (take_id_o),
        .push_lvl_i (win_lvl),
        .pop_i      (do_ret),
        .depth_o    (stk_depth),
        .top_id_o   (stk_top_id),
        .exec_lvl_o (stk_exec)
    );

    // controller state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_THREAD;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // next-state logic
    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q)
            CTL_THREAD: begin
                if (do_ack) begin
                    ctl_d = (STACK_DEPTH == 1) ? CTL_SATURATED : CTL_HANDLER;
                end
            end
            CTL_HANDLER: begin
                if (do_ret && (stk_depth == CNT_W'(1))) begin
                    ctl_d = CTL_THREAD;
                end else if (do_ack && (stk_depth == CNT_W'(STACK_DEPTH - 1))) begin
                    ctl_d = CTL_SATURATED;
                end
            end
            CTL_SATURATED: begin
                if (do_ret) begin
                    ctl_d = (STACK_DEPTH == 1) ? CTL_THREAD : CTL_HANDLER;
                end
            end
            default: ctl_d = CTL_THREAD;
        endcase
    end

    // per-state output permissions
    always_comb begin
        unique case (ctl_q)
            CTL_THREAD:    begin take_allow = 1'b1; ret_allow = 1'b0; end
            CTL_HANDLER:   begin take_allow = 1'b1; ret_allow = 1'b1; end
            CTL_SATURATED: begin take_allow = 1'b0; ret_allow = 1'b1; end
            default:       begin take_allow = 1'b0; ret_allow = 1'b0; end
        endcase
    end

    assign take_o      = win_valid && take_allow && (win_lvl < stk_exec);
    assign take_id_o   = win_id;
    assign exec_prio_o = stk_exec;
    assign do_ack      = ack_i && take_o && !ret_i;
    assign do_ret      = ret_i && ret_allow;

endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
    parameter int unsigned NUM_IRQ     = 32,
    parameter int unsigned PRIO_W      = 4,
    parameter int unsigned STACK_DEPTH = 16,
    localparam int unsigned ID_W       = $clog2(NUM_IRQ),
    localparam int unsigned LVL_W      = PRIO_W + 1,
    localparam int unsigned CNT_W      = $clog2(STACK_DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ack_i,
    input logic                 ret_i,
    input logic                 take_o,
    input logic [ID_W-1:0]      take_id_o,
    input logic [LVL_W-1:0]     exec_prio_o,
    input logic [2*NUM_IRQ-1:0] line_state_o,
    input logic [CNT_W-1:0]     depth,
    input logic [1:0]           ctl
);
    localparam logic [LVL_W-1:0] BASE = LVL_W'(1 << PRIO_W);

    logic [ID_W-1:0] id_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) id_d <= '0;
        else        id_d <= take_id_o;
    end

    AST_TAKE_IS_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (line_state_o[2*take_id_o +: 2] == 2'b01)); // R4

    AST_EXEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_prio_o <= BASE); // R5

    AST_ENTRY_RAISES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && take_o && !ret_i) |=> (exec_prio_o < $past(exec_prio_o))); // R6

    AST_ENTRY_MARKS_SERVING: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && take_o && !ret_i) |=> line_state_o[2*id_d + 1]); // R6

    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && (depth != '0)) |=> (exec_prio_o > $past(exec_prio_o))); // R7

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ack_i && take_o) && !(ret_i && (depth != '0))) |=> $stable(exec_prio_o)); // R9

    AST_THREAD_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == 2'd0) == (depth == '0)); // R9

    AST_NO_OFFER_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == CNT_W'(STACK_DEPTH)) |-> !take_o); // R9

endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(
    .NUM_IRQ     (NUM_IRQ),
    .PRIO_W      (PRIO_W),
    .STACK_DEPTH (STACK_DEPTH)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_i        (ack_i),
    .ret_i        (ret_i),
    .take_o       (take_o),
    .take_id_o    (take_id_o),
    .exec_prio_o  (exec_prio_o),
    .line_state_o (line_state_o),
    .depth        (stk_depth),
    .ctl          (ctl_q)
);

// File: tb/nest_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nest_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ack = 1'b0;
    logic        ret = 1'b0;
    logic        take;
    logic [4:0]  take_id;
    logic [4:0]  exec_prio;
    logic [63:0] line_state;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_i        (irq),
        .cfg_we_i     (cfg_we),
        .cfg_addr_i   (cfg_addr),
        .cfg_wdata_i  (cfg_wdata),
        .ack_i        (ack),
        .ret_i        (ret),
        .take_o       (take),
        .take_id_o    (take_id),
        .exec_prio_o  (exec_prio),
        .line_state_o (line_state)
    );

    typedef struct packed {
        logic [31:0] en;
        logic [31:0] pend;
        logic        exp_take;
        logic [4:0]  exp_id;
    } vec_t;

    // urgency: 3->5, 7->2, 9->2, 20->1, all others 15
    localparam vec_t VECS [8] = '{
        '{32'hFFFF_FFFF, 32'h0000_0408, 1'b1, 5'd3},
        '{32'hFFFF_FFFF, 32'h0000_0280, 1'b1, 5'd7},
        '{32'hFFFF_FFFF, 32'h0010_0200, 1'b1, 5'd20},
        '{32'hFFEF_FFFF, 32'h0010_0200, 1'b1, 5'd9},
        '{32'h0000_0000, 32'h0000_0008, 1'b0, 5'd0},
        '{32'hFFFF_FFFF, 32'hC000_0000, 1'b1, 5'd30},
        '{32'h8000_0000, 32'hC000_0000, 1'b1, 5'd31},
        '{32'hFFFF_FFFF, 32'h0000_0009, 1'b1, 5'd3}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_offer(input string req, input logic exp_take, input logic [4:0] exp_id);
        chk(req, {63'd0, take}, {63'd0, exp_take});
        if (exp_take) chk(req, {59'd0, take_id}, {59'd0, exp_id});
    endtask

    function automatic logic [1:0] st(input int n);
        return line_state[2*n +: 2];
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] m);
        @(negedge clk); irq = m;
        @(negedge clk); irq = '0;
    endtask

    task automatic enter();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic leave();
        @(negedge clk); ret = 1'b1;
        @(negedge clk); ret = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 take", {63'd0, take}, 64'd0);
        chk("R1 exec", {59'd0, exec_prio}, 64'd16);
        chk("R1 R8 status", line_state, 64'd0);
        pulse(32'h0000_0020);
        chk("R3 R8 line5 waiting", {62'd0, st(5)}, 64'd1);
        chk("R1 disabled no take", {63'd0, take}, 64'd0);
        wr(8'h00, 32'hFFFF_FFFF);
        chk_offer("R5 enabled take", 1'b1, 5'd5);
        pulse(32'h0000_0004);
        chk_offer("R1 R4 equal zero urgency lower id", 1'b1, 5'd2);
        wr(8'h02, 32'hFFFF_FFFF);
        chk("R3 clear all", line_state, 64'd0);

        // urgency setup for the table
        for (int n = 0; n < 32; n++) wr(8'h20 + 8'(n), 32'hF0);
        wr(8'h23, 32'h50);
        wr(8'h27, 32'h20);
        wr(8'h29, 32'h20);
        wr(8'h34, 32'h10);

        // R4 R5 arbitration table
        for (int v = 0; v < 8; v++) begin
            wr(8'h02, 32'hFFFF_FFFF);
            wr(8'h00, VECS[v].en);
            pulse(VECS[v].pend);
            chk_offer($sformatf("R4 R5 vector %0d", v), VECS[v].exp_take, VECS[v].exp_id);
        end
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);

        // R2 only top urgency bits kept: 0x4F and 0x40 tie
        wr(8'h28, 32'h4F);
        wr(8'h29, 32'h40);
        pulse(32'h0000_0300);
        chk_offer("R2 low bits dropped", 1'b1, 5'd8);
        wr(8'h00, 32'h0);
        chk("R5 disabled not offered", {63'd0, take}, 64'd0);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);

        // nesting, split 0
        wr(8'h24, 32'h80);
        wr(8'h25, 32'h80);
        wr(8'h26, 32'h30);
        wr(8'h01, 32'h0000_0010);
        chk_offer("R3 software set offered", 1'b1, 5'd4);
        enter();
        chk("R6 exec", {59'd0, exec_prio}, 64'd8);
        chk("R6 serving", {62'd0, st(4)}, 64'd2);
        pulse(32'h0000_0020);
        chk("R10 equal group held", {63'd0, take}, 64'd0);
        pulse(32'h0000_0040);
        chk_offer("R5 more urgent pre-empts", 1'b1, 5'd6);
        enter();
        chk("R6 nested exec", {59'd0, exec_prio}, 64'd3);
        leave();
        chk("R7 restore exec", {59'd0, exec_prio}, 64'd8);
        chk("R7 line6 idle", {62'd0, st(6)}, 64'd0);
        chk("R10 still held", {63'd0, take}, 64'd0);
        leave();
        chk("R7 base exec", {59'd0, exec_prio}, 64'd16);
        chk_offer("R7 waiting line offered", 1'b1, 5'd5);
        enter();
        leave();
        chk("R7 after unwind", {63'd0, take}, 64'd0);

        // split 2: group = urgency >> 2
        wr(8'h03, 32'h2);
        wr(8'h24, 32'hA0);
        wr(8'h25, 32'h80);
        wr(8'h26, 32'h40);
        pulse(32'h0000_0010);
        enter();
        chk("R2 R6 group exec", {59'd0, exec_prio}, 64'd2);
        pulse(32'h0000_0020);
        chk("R10 better sub same group held", {63'd0, take}, 64'd0);
        pulse(32'h0000_0040);
        chk_offer("R4 R5 lower group offered", 1'b1, 5'd6);
        enter();
        chk("R6 exec group1", {59'd0, exec_prio}, 64'd1);
        leave();
        chk("R7 exec group2", {59'd0, exec_prio}, 64'd2);
        leave();
        chk_offer("R7 sub-priority line now offered", 1'b1, 5'd5);
        enter();
        leave();
        // split 7 acts as 4: every group is 0
        wr(8'h03, 32'h7);
        pulse(32'h0000_0010);
        enter();
        chk("R2 clamp exec", {59'd0, exec_prio}, 64'd0);
        pulse(32'h0000_0040);
        chk("R2 clamp no pre-emption", {63'd0, take}, 64'd0);
        leave();
        wr(8'h02, 32'hFFFF_FFFF);
        wr(8'h03, 32'h0);

        // R6 R7 in service with a new request
        pulse(32'h0000_0400);
        @(negedge clk); ack = 1'b1; irq = 32'h0000_0400;
        @(negedge clk); ack = 1'b0; irq = '0;
        chk("R6 R8 serv+wait", {62'd0, st(10)}, 64'd3);
        leave();
        chk("R7 R8 back to waiting", {62'd0, st(10)}, 64'd1);
        chk_offer("R7 re-offered", 1'b1, 5'd10);
        enter();
        pulse(32'h0000_0400);
        chk("R8 serv+wait later", {62'd0, st(10)}, 64'd3);
        leave();
        wr(8'h02, 32'h0000_0400);
        chk("R3 cleared", {62'd0, st(10)}, 64'd0);

        // R3 set beats clear
        @(negedge clk);
        irq = 32'h0000_0800; cfg_we = 1'b1; cfg_addr = 8'h02; cfg_wdata = 32'h0000_0800;
        @(negedge clk);
        irq = '0; cfg_we = 1'b0;
        chk("R3 set wins", {62'd0, st(11)}, 64'd1);
        wr(8'h02, 32'hFFFF_FFFF);

        // R9 ignored handshakes
        leave();
        chk("R9 ret idle", {59'd0, exec_prio}, 64'd16);
        enter();
        chk("R9 ack without offer", {59'd0, exec_prio}, 64'd16);
        pulse(32'h0000_1000);
        @(negedge clk); ack = 1'b1; ret = 1'b1;
        @(negedge clk); ack = 1'b0; ret = 1'b0;
        chk("R9 ack with ret exec", {59'd0, exec_prio}, 64'd16);
        chk("R9 ack with ret state", {62'd0, st(12)}, 64'd1);
        wr(8'h02, 32'hFFFF_FFFF);

        // R9 fill the stack to 16
        for (int i = 0; i < 16; i++) begin
            wr(8'h20 + 8'(i), 32'((15 - i) << 4));
            wr(8'h01, 32'(1) << i);
            chk_offer($sformatf("R5 nest level %0d", i), 1'b1, 5'(i));
            enter();
            chk($sformatf("R6 nest exec %0d", i), {59'd0, exec_prio}, 64'(15 - i));
        end
        pulse(32'h0001_0000);
        chk("R9 full no offer", {63'd0, take}, 64'd0);
        for (int i = 15; i >= 0; i--) begin
            leave();
            chk($sformatf("R7 unwind %0d", i), {59'd0, exec_prio}, 64'(16 - i));
        end
        chk_offer("R7 unwound offer", 1'b1, 5'd16);

        finish_run();
    end

endmodule